// File: doc/BRIEF.md
# Power-Up Register Bring-Up Sequencer

This block drives an imaging front-end device from power-on to running clock outputs by issuing an ordered list of register writes on a generic request channel. Each request carries an address and a data word. A request is offered with `wr_valid` and completes when the downstream serial-link engine raises `wr_ready`. The list has a fixed order:
1. a self-clearing soft reset;
2. the user configuration entries, which include the mandatory test-mode values, in table order;
3. a single write that leaves standby and powers up the reference buffer;
4. a start of the timing core;
5. output enable.

The user entries are held in a small internal table. The host, or the bench, loads it through a table write port before starting. A `start` pulse arms the sequencer. It then waits until both the supply-good and input-clock-running indications are high, seen through a two-stage synchronizer, and only then issues the first write.

The controller is an eight-state machine. The states and transitions are:
- `ST_IDLE`: moves to `ST_WAIT_PWR` on `start`.
- `ST_WAIT_PWR`: moves to `ST_SOFT_RST` once the synchronized supply and clock indications are both high.
- `ST_SOFT_RST`: on acceptance, moves to `ST_CFG`, or to `ST_STBY_EXIT` if the captured table length is zero.
- `ST_CFG`: steps through the table index on each acceptance, and after the last entry moves to `ST_STBY_EXIT`.
- `ST_STBY_EXIT`: moves to `ST_CORE_RST` on acceptance.
- `ST_CORE_RST`: moves to `ST_OUT_EN` on acceptance.
- `ST_OUT_EN`: moves to `ST_FINISH` on acceptance.
- `ST_FINISH`: pulses `done` and returns to `ST_IDLE`.

A synchronous reset returns the machine to `ST_IDLE` from any state.

Top module: `bringup_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it, `busy`, `wr_valid` and `done` are 0.
- R2: After `start` is accepted in idle, no write is offered until `supply_ok` and `clkin_ok` have both been high. Each is delayed by two clock cycles through a synchronizer, and the two may rise in either order.
- R3: The first write is address 0x10 with data 0x0001, the soft reset. No write that clears it follows.
- R4: Table entries 0 to N-1 are written next, in index order, with their stored address and data. N is `cfg_len` captured at `start` and limited to CFG_DEPTH. When N is 0 the table step is skipped.
- R5: Next, address 0x00 is written exactly once with data 0, which clears the standby field in bits [1:0] and the buffer power-down in bit 2 together.
- R6: Next, address 0x14 is written with data 0x0001, which starts the timing core.
- R7: The final write is address 0x11 with data 0x0001, which enables the outputs.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold. The sequence advances only on a cycle with both high.
- R9: `done` is high for exactly one cycle, the cycle after the final write is accepted. `busy` is high from the cycle after `start` until that pulse ends.
- R10: `start` while `busy` is high has no effect on the write order or timing.
- R11: A synchronous reset in the middle of a sequence returns the block to idle on the next cycle, with `wr_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin the bring-up sequence (taken only in idle) |
| supply_ok | input | 1 | Supplies up (asynchronous) |
| clkin_ok | input | 1 | Device input clock running (asynchronous) |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W | Table entry index |
| tbl_addr | input | ADDR_W | Register address stored in the entry |
| tbl_data | input | DATA_W | Register data stored in the entry |
| cfg_len | input | LEN_W | Number of table entries to send |
| wr_valid | output | 1 | Write request offered |
| wr_addr | output | ADDR_W | Write request address |
| wr_data | output | DATA_W | Write request data |
| wr_ready | input | 1 | Downstream accepts the request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports involve the power gate and backpressure acting together. One is a start that arrives while the supply and clock indications are low and then rise one at a time, so the two-cycle synchronizer delay decides the first write cycle. Another is a long stalled handshake on a table entry while `start` is pulsed again. The stimulus arms the block with both indications low and raises them several cycles apart in both orders. It drives `wr_ready` with always-ready, random and one-in-four patterns. It also requests more entries than the table holds, asks for none, and pulses `start` and `rst` part-way through a run. A behavioural queue model predicts every output on every cycle.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_PWR,
        ST_SOFT_RST,
        ST_CFG,
        ST_STBY_EXIT,
        ST_CORE_RST,
        ST_OUT_EN,
        ST_FINISH
    } seq_state_t;

    // Register addresses of the fixed steps (order of use is behaviour)
    localparam logic [7:0] REG_SOFT_RST = 8'h10;
    localparam logic [7:0] REG_POWER    = 8'h00;
    localparam logic [7:0] REG_CORE_RST = 8'h14;
    localparam logic [7:0] REG_OUT_CTL  = 8'h11;

endpackage

// File: rtl/bringup_sync.sv
module bringup_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

endmodule

// File: rtl/bringup_cfg_table.sv
module bringup_cfg_table #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [DATA_W-1:0] ent_data [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we && (widx == IDX_W'(i))) begin
                ent_addr[i] <= waddr;
                ent_data[i] <= wdata;
            end
        end
    end

    always_comb begin
        raddr = '0;
        rdata = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (ridx == IDX_W'(j)) begin
                raddr = ent_addr[j];
                rdata = ent_data[j];
            end
        end
    end

endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm
    import bringup_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int LEN_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              pwr_ok,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [ADDR_W-1:0] tbl_raddr,
    input  logic [DATA_W-1:0] tbl_rdata,
    output logic [IDX_W-1:0]  tbl_ridx,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              busy,
    output logic              done
);

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DEPTH);
    localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [LEN_W-1:0] len_q, len_d;
    logic             accept;
    logic             last_entry;

    assign accept     = wr_valid && wr_ready;
    assign last_entry = (LEN_W'(idx_q) == (len_q - LEN_W'(1)));

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            len_q   <= len_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        len_d   = len_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    len_d   = (cfg_len > LEN_MAX) ? LEN_MAX : cfg_len;
                    idx_d   = '0;
                    state_d = ST_WAIT_PWR;
                end
            end
            ST_WAIT_PWR: begin
                if (pwr_ok) state_d = ST_SOFT_RST;
            end
            ST_SOFT_RST: begin
                if (accept) begin
                    idx_d   = '0;
                    state_d = (len_q == '0) ? ST_STBY_EXIT : ST_CFG;
                end
            end
            ST_CFG: begin
                if (accept) begin
                    if (last_entry) state_d = ST_STBY_EXIT;
                    else            idx_d   = idx_q + IDX_W'(1);
                end
            end
            ST_STBY_EXIT: begin
                if (accept) state_d = ST_CORE_RST;
            end
            ST_CORE_RST: begin
                if (accept) state_d = ST_OUT_EN;
            end
            ST_OUT_EN: begin
                if (accept) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output decode
    always_comb begin
        wr_valid = 1'b0;
        wr_addr  = '0;
        wr_data  = '0;
        done     = 1'b0;
        busy     = (state_q != ST_IDLE);
        tbl_ridx = idx_q;
        unique case (state_q)
            ST_IDLE, ST_WAIT_PWR: begin
                wr_valid = 1'b0;
            end
            ST_SOFT_RST: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_W'(REG_SOFT_RST);
                wr_data  = ONE;
            end
            ST_CFG: begin
                wr_valid = 1'b1;
                wr_addr  = tbl_raddr;
                wr_data  = tbl_rdata;
            end
            ST_STBY_EXIT: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_W'(REG_POWER);
                wr_data  = '0;
            end
            ST_CORE_RST: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_W'(REG_CORE_RST);
                wr_data  = ONE;
            end
            ST_OUT_EN: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_W'(REG_OUT_CTL);
                wr_data  = ONE;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
        endcase
    end

    // Request held under backpressure (R8)
    assert_hold_request_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // A sequence always opens with the soft reset write (R3)
    assert_first_write_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_valid) |-> (wr_addr == ADDR_W'(REG_SOFT_RST) && wr_data == ONE));

    // done is a single-cycle pulse (R9)
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // done follows acceptance of the output-enable write (R7)
    assert_done_after_outen_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr_valid && wr_ready && wr_addr == ADDR_W'(REG_OUT_CTL)));

    // A running sequence is not restarted or dropped by start (R10)
    assert_busy_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // Table index stays inside the captured length (R4)
    assert_index_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CFG) |-> (LEN_W'(idx_q) < len_q));

endmodule

// File: rtl/bringup_seq.sv
module bringup_seq #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int CFG_DEPTH = 8,
    parameter int IDX_W     = $clog2(CFG_DEPTH),
    parameter int LEN_W     = $clog2(CFG_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              supply_ok,
    input  logic              clkin_ok,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [DATA_W-1:0] tbl_data,
    input  logic [LEN_W-1:0]  cfg_len,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              busy,
    output logic              done
);

    logic [1:0]        pwr_sync;
    logic              pwr_ok;
    logic [IDX_W-1:0]  rd_idx;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    bringup_sync #(.WIDTH(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({supply_ok, clkin_ok}),
        .q   (pwr_sync)
    );

    assign pwr_ok = &pwr_sync;

    bringup_cfg_table #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (CFG_DEPTH),
        .IDX_W  (IDX_W)
    ) u_table (
        .clk   (clk),
        .we    (tbl_we),
        .widx  (tbl_idx),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .ridx  (rd_idx),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    bringup_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (CFG_DEPTH),
        .IDX_W  (IDX_W),
        .LEN_W  (LEN_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .pwr_ok    (pwr_ok),
        .cfg_len   (cfg_len),
        .tbl_raddr (rd_addr),
        .tbl_rdata (rd_data),
        .tbl_ridx  (rd_idx),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_ready  (wr_ready),
        .busy      (busy),
        .done      (done)
    );

endmodule

// File: tb/bringup_seq_tb.sv
module bringup_seq_tb;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 8;
    localparam int IDX_W  = 3;
    localparam int LEN_W  = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic              rst, start, supply_ok, clkin_ok, tbl_we;
    logic [IDX_W-1:0]  tbl_idx;
    logic [ADDR_W-1:0] tbl_addr;
    logic [DATA_W-1:0] tbl_data;
    logic [LEN_W-1:0]  cfg_len;
    logic              wr_valid, wr_ready, busy, done;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    bringup_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .start(start), .supply_ok(supply_ok), .clkin_ok(clkin_ok),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .cfg_len(cfg_len), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .busy(busy), .done(done)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [ADDR_W-1:0] mir_addr [DEPTH];
    logic [DATA_W-1:0] mir_data [DEPTH];
    logic [ADDR_W+DATA_W-1:0] m_q [$];
    int   m_phase = 0;   // 0 idle, 1 waiting for power, 2 writing, 3 done pulse
    int   m_k = 0;
    bit   m_live = 0;
    bit   m_stalled = 0;
    logic m_s1 = 0, m_s2 = 0, m_c1 = 0, m_c2 = 0;

    always @(posedge clk) begin
        m_live = 1;
        if (tbl_we) begin
            mir_addr[tbl_idx] = tbl_addr;
            mir_data[tbl_idx] = tbl_data;
        end
        if (rst) begin
            m_phase = 0; m_k = 0; m_stalled = 0;
            m_s1 = 0; m_s2 = 0; m_c1 = 0; m_c2 = 0;
        end else begin
            m_stalled = (m_phase == 2) && !wr_ready;
            case (m_phase)
                0: if (start) begin
                    int n;
                    n = (int'(cfg_len) > DEPTH) ? DEPTH : int'(cfg_len);
                    m_q.delete();
                    m_q.push_back({8'h10, 16'h0001});
                    for (int i = 0; i < n; i++) m_q.push_back({mir_addr[i], mir_data[i]});
                    m_q.push_back({8'h00, 16'h0000});
                    m_q.push_back({8'h14, 16'h0001});
                    m_q.push_back({8'h11, 16'h0001});
                    m_phase = 1;
                end
                1: if (m_s2 && m_c2) begin m_phase = 2; m_k = 0; end
                2: if (wr_ready) begin
                    m_k++;
                    if (m_k == m_q.size()) m_phase = 3;
                end
                default: m_phase = 0;
            endcase
            m_s2 = m_s1; m_s1 = supply_ok;
            m_c2 = m_c1; m_c1 = clkin_ok;
        end
    end

    function automatic string tag_for(input logic [ADDR_W-1:0] a);
        case (a)
            8'h10:   return "R3";
            8'h00:   return "R5";
            8'h14:   return "R6";
            8'h11:   return "R7";
            default: return "R4";
        endcase
    endfunction

    always @(negedge clk) begin
        if (m_live) begin
            string tag;
            logic [ADDR_W-1:0] ea;
            logic [DATA_W-1:0] ed;
            ea = '0; ed = '0;
            if (m_phase == 2) {ea, ed} = m_q[m_k];
            if (rst)                        tag = "R11";
            else if (start && m_phase != 0) tag = "R10";
            else if (m_phase == 0)          tag = "R11";
            else if (m_phase == 1)          tag = "R2";
            else if (m_phase == 3)          tag = "R9";
            else if (m_stalled)             tag = "R8";
            else                            tag = tag_for(ea);
            chk(busy == (m_phase != 0), tag, "busy", 32'(busy), 32'(m_phase != 0));
            chk(wr_valid == (m_phase == 2), tag, "wr_valid", 32'(wr_valid), 32'(m_phase == 2));
            chk(done == (m_phase == 3), tag, "done", 32'(done), 32'(m_phase == 3));
            if (m_phase == 2) begin
                chk(wr_addr == ea, tag, "wr_addr", 32'(wr_addr), 32'(ea));
                chk(wr_data == ed, tag, "wr_data", 32'(wr_data), 32'(ed));
            end
        end
    end

    // ---------------- downstream ready generator ----------------
    int rdy_mode = 0;
    int rdy_cnt  = 0;
    always @(posedge clk) begin
        #5;
        rdy_cnt++;
        case (rdy_mode)
            0:       wr_ready = 1'b1;
            1:       wr_ready = 1'($urandom_range(0, 1));
            default: wr_ready = (rdy_cnt % 4 == 0);
        endcase
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic load(input int i, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        tbl_we = 1'b1; tbl_idx = IDX_W'(i); tbl_addr = a; tbl_data = d;
        tick();
        tbl_we = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 2000 && busy; n++) tick();
        tick();
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; supply_ok = 1'b0; clkin_ok = 1'b0;
        tbl_we = 1'b0; tbl_idx = '0; tbl_addr = '0; tbl_data = '0; cfg_len = '0;
        wr_ready = 1'b0;
        repeat (3) tick();
        // R1: reset state at the ports
        chk(busy == 1'b0, "R1", "busy in reset", 32'(busy), 0);
        chk(wr_valid == 1'b0, "R1", "wr_valid in reset", 32'(wr_valid), 0);
        chk(done == 1'b0, "R1", "done in reset", 32'(done), 0);
        rst = 1'b0;
        tick();

        // R4: three entries, always ready, power already good
        load(0, 8'h21, 16'hA5A5);
        load(1, 8'h22, 16'h0F0F);
        load(2, 8'h3C, 16'h1234);
        supply_ok = 1'b1; clkin_ok = 1'b1;
        cfg_len = 4'd3; rdy_mode = 0;
        repeat (3) tick();
        pulse_start();
        wait_idle();

        // R2: power indications rise late, clock first, random ready
        supply_ok = 1'b0; clkin_ok = 1'b0;
        repeat (3) tick();
        rdy_mode = 1;
        pulse_start();
        repeat (6) tick();
        clkin_ok = 1'b1;
        repeat (5) tick();
        supply_ok = 1'b1;
        wait_idle();

        // R2: supply first this time; R4 empty table; slow ready (R8)
        supply_ok = 1'b0; clkin_ok = 1'b0;
        cfg_len = 4'd0; rdy_mode = 2;
        repeat (3) tick();
        pulse_start();
        repeat (4) tick();
        supply_ok = 1'b1;
        repeat (3) tick();
        clkin_ok = 1'b1;
        wait_idle();

        // R4: length above depth is limited; R10: start pulses while busy
        for (int i = 0; i < DEPTH; i++) load(i, ADDR_W'(8'h40 + i), DATA_W'(16'h0100 * (i + 1) + i));
        cfg_len = 4'd12; rdy_mode = 1;
        pulse_start();
        repeat (5) tick();
        pulse_start();
        repeat (7) tick();
        pulse_start();
        wait_idle();

        // R11: reset part-way, then a clean run with stalls
        cfg_len = 4'd5; rdy_mode = 2;
        pulse_start();
        repeat (9) tick();
        rst = 1'b1;
        tick();
        chk(wr_valid == 1'b0, "R11", "wr_valid after reset", 32'(wr_valid), 0);
        chk(busy == 1'b0, "R11", "busy after reset", 32'(busy), 0);
        rst = 1'b0;
        tick();
        rdy_mode = 1;
        pulse_start();
        wait_idle();

        repeat (4) tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not complete at %0t", $time);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule